// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers ten interrupt request sources, four external request pins and six on-chip requesters (two timers, a software watchdog, two serial ports and a two-wire bus controller), and reduces them to a single priority level for the processor. Each request is latched into a pending bit. Every source has a priority level from 1 to 7 and a 2-bit sub-priority that breaks ties within a level. The external pins take their levels from one of two fixed maps, which a configuration input selects. The internal sources take whatever level is written into their configuration.

The block presents the highest pending level, together with a take flag that compares that level against the processor's 3-bit interrupt mask. When the processor later runs an acknowledge cycle for a level, the block answers one cycle later. The answer is either the winning source's programmed vector number or an autovector indication. The acknowledged source's pending bit is then cleared. The exception table and the processor's exception sequencing lie outside this block.

Top module: `irq_level_ctrl`

## Requirements
- R1: After synchronous reset, irq_lvl, irq_take, iack_done and iack_spur are 0. Every internal source (indices 4 to 9) has level 0, and every source has autovector mode set, sub-priority 0 and vector 0.
- R2: With map_sel=0, external pins 0, 1, 2 and 3 (source indices 0 to 3) sit at levels 1, 3, 5 and 7. With map_sel=1 they sit at levels 2, 4, 6 and 7. A configuration write of a level to indices 0 to 3 has no effect on their level.
- R3: Internal sources 4 to 9 (int_req bit k is source 4+k) take the level written by cfg_we with cfg_lvl. A source whose level is 0 is disabled: it never drives irq_lvl and never wins an acknowledge.
- R4: irq_lvl equals the highest level among pending, enabled sources, or 0 if there are none. A request sampled high at a clock edge appears on irq_lvl at the following edge.
- R5: irq_take is 1 exactly when irq_lvl is nonzero and is either greater than mask or equal to 7. Level 7 is therefore taken even when mask is 7.
- R6: Among pending sources at the same level, the one with the larger sub-priority wins (3 highest). When sub-priorities are also equal, the lower source index wins.
- R7: An acknowledge request (iack_req with iack_lvl) sampled at an edge produces a one-cycle iack_done after that edge. If the winning source at iack_lvl has autovector mode clear, iack_vec is its programmed vector and iack_auto is 0.
- R8: If the winning source has autovector mode set, iack_vec is 24 plus the acknowledged level and iack_auto is 1.
- R9: If no pending, enabled source sits at iack_lvl, the response has iack_spur=1, iack_auto=1 and iack_vec=24.
- R10: A request pulse stays pending until that source wins an acknowledge cycle. The acknowledge clears only the winner's pending bit. A request and a clear in the same cycle leave the bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 4 | External interrupt request pins |
| int_req | input | 6 | Internal requests: timer 0, timer 1, software watchdog, serial 0, serial 1, two-wire bus |
| map_sel | input | 1 | External level map select (0: 1/3/5/7, 1: 2/4/6/7) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Source index being configured |
| cfg_lvl | input | 3 | Level to write (internal sources only) |
| cfg_sub | input | 2 | Sub-priority to write |
| cfg_vec | input | 8 | Vector number to write |
| cfg_auto | input | 1 | Autovector mode to write |
| mask | input | 3 | Processor interrupt mask |
| iack_req | input | 1 | Acknowledge cycle request |
| iack_lvl | input | 3 | Level being acknowledged |
| irq_lvl | output | 3 | Highest pending enabled level |
| irq_take | output | 1 | Pending level passes the mask |
| iack_done | output | 1 | Acknowledge response valid |
| iack_vec | output | 8 | Returned vector number |
| iack_auto | output | 1 | Response is an autovector |
| iack_spur | output | 1 | No source at the acknowledged level |

## Verification
The bound checker watches, on every cycle, that each acknowledge request is answered exactly one cycle later and that no answer appears without one. It also watches that an autovector answer carries 24 plus the acknowledged level, that a spurious answer is also an autovector, and that the take flag only rises with a nonzero level at or above the mask rule. Several behaviours can only be shown by the bench's scenarios: which source wins a tie, the level maps for the external pins, whether pending bits survive or clear across acknowledges, and whether the level written for a disabled or external source is honoured or ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int SUB_W = 2;
  localparam int VEC_W = 8;
  localparam logic [LVL_W-1:0] LVL_NMI = '1;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [SUB_W-1:0] sub;
    logic [VEC_W-1:0] vec;
    logic             autov;
  } src_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int N_INT = 6,
  localparam int NSRC  = N_EXT + N_INT,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             map_sel,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic [SUB_W-1:0] cfg_sub,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             cfg_auto,
  output src_cfg_t         cfg_o [NSRC]
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic             hit;
    logic [SUB_W-1:0] sub_q;
    logic [VEC_W-1:0] vec_q;
    logic             auto_q;

    assign hit = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        sub_q  <= '0;
        vec_q  <= '0;
        auto_q <= 1'b1;
      end else if (hit) begin
        sub_q  <= cfg_sub;
        vec_q  <= cfg_vec;
        auto_q <= cfg_auto;
      end
    end

    if (i < N_EXT) begin : g_ext
      // Fixed map: odd levels or even levels, last pin pinned to the top level.
      logic [LVL_W-1:0] map_lvl;
      always_comb begin
        if (i == N_EXT - 1) map_lvl = LVL_NMI;
        else                map_lvl = LVL_W'(2 * i + 1) + LVL_W'(map_sel);
      end
      assign cfg_o[i] = '{lvl: map_lvl, sub: sub_q, vec: vec_q, autov: auto_q};
    end else begin : g_int
      logic [LVL_W-1:0] lvl_q;
      always_ff @(posedge clk) begin
        if (rst)      lvl_q <= '0;
        else if (hit) lvl_q <= cfg_lvl;
      end
      assign cfg_o[i] = '{lvl: lvl_q, sub: sub_q, vec: vec_q, autov: auto_q};
    end
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | req) & ~clr;
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int NSRC = 10,
  localparam int IDX_W = $clog2(NSRC),
  localparam int KEY_W = LVL_W + SUB_W
) (
  input  logic [NSRC-1:0]  pend,
  input  src_cfg_t         cfg [NSRC],
  input  logic             match_en,
  input  logic [LVL_W-1:0] match_lvl,
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output logic [LVL_W-1:0] win_lvl
);
  logic [KEY_W-1:0] best_key;

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    best_key = '0;
    // Ascending scan with strict compare: lower index keeps a full tie.
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (cfg[i].lvl != '0) &&
          (!match_en || (cfg[i].lvl == match_lvl)) &&
          (!found || ({cfg[i].lvl, cfg[i].sub} > best_key))) begin
        found    = 1'b1;
        best_key = {cfg[i].lvl, cfg[i].sub};
        win_idx  = IDX_W'(i);
      end
    end
    win_lvl = best_key[KEY_W-1:SUB_W];
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT     = 4,
  parameter int N_INT     = 6,
  parameter int AUTO_BASE = 24,
  localparam int NSRC  = N_EXT + N_INT,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_INT-1:0] int_req,
  input  logic             map_sel,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic [SUB_W-1:0] cfg_sub,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             cfg_auto,
  input  logic [LVL_W-1:0] mask,
  input  logic             iack_req,
  input  logic [LVL_W-1:0] iack_lvl,
  output logic [LVL_W-1:0] irq_lvl,
  output logic             irq_take,
  output logic             iack_done,
  output logic [VEC_W-1:0] iack_vec,
  output logic             iack_auto,
  output logic             iack_spur
);
  src_cfg_t         cfg [NSRC];
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  clr;
  logic             top_found, ack_found;
  logic [IDX_W-1:0] top_idx, ack_idx;
  logic [LVL_W-1:0] top_lvl, ack_lvl;

  irq_cfg_regs #(.N_EXT(N_EXT), .N_INT(N_INT)) u_cfg (
    .clk(clk), .rst(rst), .map_sel(map_sel), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cfg_sub(cfg_sub),
    .cfg_vec(cfg_vec), .cfg_auto(cfg_auto), .cfg_o(cfg)
  );

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req({int_req, ext_req}), .clr(clr), .pend(pend)
  );

  irq_arb #(.NSRC(NSRC)) u_arb_top (
    .pend(pend), .cfg(cfg), .match_en(1'b0), .match_lvl('0),
    .found(top_found), .win_idx(top_idx), .win_lvl(top_lvl)
  );

  irq_arb #(.NSRC(NSRC)) u_arb_ack (
    .pend(pend), .cfg(cfg), .match_en(1'b1), .match_lvl(iack_lvl),
    .found(ack_found), .win_idx(ack_idx), .win_lvl(ack_lvl)
  );

  always_comb begin
    clr = '0;
    if (iack_req && ack_found) clr[ack_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl  <= '0;
      irq_take <= 1'b0;
    end else begin
      irq_lvl  <= top_found ? top_lvl : '0;
      irq_take <= top_found && ((top_lvl > mask) || (top_lvl == LVL_NMI));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iack_done <= 1'b0;
      iack_vec  <= '0;
      iack_auto <= 1'b0;
      iack_spur <= 1'b0;
    end else begin
      iack_done <= iack_req;
      iack_vec  <= '0;
      iack_auto <= 1'b0;
      iack_spur <= 1'b0;
      if (iack_req) begin
        if (!ack_found) begin
          iack_vec  <= VEC_W'(AUTO_BASE);
          iack_auto <= 1'b1;
          iack_spur <= 1'b1;
        end else if (cfg[ack_idx].autov) begin
          iack_vec  <= VEC_W'(AUTO_BASE) + VEC_W'(ack_lvl);
          iack_auto <= 1'b1;
        end else begin
          iack_vec  <= cfg[ack_idx].vec;
        end
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_pkg::*;
#(
  parameter int AUTO_BASE = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] mask,
  input logic             iack_req,
  input logic [LVL_W-1:0] iack_lvl,
  input logic [LVL_W-1:0] irq_lvl,
  input logic             irq_take,
  input logic             iack_done,
  input logic [VEC_W-1:0] iack_vec,
  input logic             iack_auto,
  input logic             iack_spur
);
  // R5: take flag only with a nonzero level that passes the mask or is top level
  assert_take_valid_R5: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (irq_lvl != '0) && ((irq_lvl > mask) || (irq_lvl == LVL_NMI)));

  // R7: every acknowledge request answered one cycle later
  assert_ack_resp_R7: assert property (@(posedge clk) disable iff (rst)
    iack_req |=> iack_done);

  // R7: no answer without a request
  assert_no_stray_ack_R7: assert property (@(posedge clk) disable iff (rst)
    !iack_req |=> !iack_done);

  // R8: autovector answers carry base plus acknowledged level
  assert_autovec_num_R8: assert property (@(posedge clk) disable iff (rst)
    (iack_done && iack_auto && !iack_spur) |->
      (iack_vec == VEC_W'(AUTO_BASE) + VEC_W'($past(iack_lvl))));

  // R9: spurious answer is an autovector with the base number
  assert_spur_form_R9: assert property (@(posedge clk) disable iff (rst)
    iack_spur |-> (iack_done && iack_auto && (iack_vec == VEC_W'(AUTO_BASE))));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.AUTO_BASE(AUTO_BASE)) u_chk (
  .clk(clk), .rst(rst), .mask(mask), .iack_req(iack_req), .iack_lvl(iack_lvl),
  .irq_lvl(irq_lvl), .irq_take(irq_take), .iack_done(iack_done),
  .iack_vec(iack_vec), .iack_auto(iack_auto), .iack_spur(iack_spur)
);

// File: tb/sim_irq_level_ctrl.sv
module sim_irq_level_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ext_req = '0;
  logic [5:0] int_req = '0;
  logic       map_sel = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [2:0] cfg_lvl = '0;
  logic [1:0] cfg_sub = '0;
  logic [7:0] cfg_vec = '0;
  logic       cfg_auto = 1'b0;
  logic [2:0] mask = '0;
  logic       iack_req = 1'b0;
  logic [2:0] iack_lvl = '0;
  logic [2:0] irq_lvl;
  logic       irq_take, iack_done, iack_auto, iack_spur;
  logic [7:0] iack_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_level_ctrl u0 (
    .clk(clk), .rst(rst), .ext_req(ext_req), .int_req(int_req), .map_sel(map_sel),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cfg_sub(cfg_sub),
    .cfg_vec(cfg_vec), .cfg_auto(cfg_auto), .mask(mask), .iack_req(iack_req),
    .iack_lvl(iack_lvl), .irq_lvl(irq_lvl), .irq_take(irq_take),
    .iack_done(iack_done), .iack_vec(iack_vec), .iack_auto(iack_auto),
    .iack_spur(iack_spur)
  );

  // {req[9:0], mask, expected level, expected take}; sources per setup_cfg
  localparam int NV = 8;
  localparam logic [16:0] VECS [NV] = '{
    {10'h001, 3'd0, 3'd1, 1'b1},
    {10'h001, 3'd1, 3'd1, 1'b0},
    {10'h040, 3'd0, 3'd0, 1'b0},
    {10'h012, 3'd2, 3'd3, 1'b1},
    {10'h090, 3'd4, 3'd4, 1'b0},
    {10'h008, 3'd7, 3'd7, 1'b1},
    {10'h020, 3'd5, 3'd6, 1'b1},
    {10'h200, 3'd7, 3'd7, 1'b1}
  };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    ext_req = '0; int_req = '0; iack_req = 1'b0; cfg_we = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(int idx, int lvl, int sub, int vec, bit au);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_lvl = 3'(lvl);
    cfg_sub = 2'(sub); cfg_vec = 8'(vec); cfg_auto = au;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic setup_cfg();
    wr(4, 2, 1, 8'h10, 1'b1);
    wr(5, 6, 0, 8'h20, 1'b1);
    wr(6, 0, 3, 8'h30, 1'b0);
    wr(7, 4, 2, 8'h40, 1'b0);
    wr(8, 4, 2, 8'h48, 1'b0);
    wr(9, 7, 3, 8'h50, 1'b1);
  endtask

  // Pulse requests for one cycle; return at the negedge where irq_lvl is valid.
  task automatic pulse(logic [9:0] r);
    @(negedge clk); {int_req, ext_req} = r;
    @(negedge clk); {int_req, ext_req} = '0;
    @(negedge clk);
  endtask

  task automatic ack(int lvl);
    @(negedge clk); iack_req = 1'b1; iack_lvl = 3'(lvl);
    @(negedge clk); iack_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Table walk: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      do_reset();
      setup_cfg();
      mask = VECS[v][6:4];
      pulse(VECS[v][16:7]);
      chk($sformatf("R4 vec%0d irq_lvl", v), int'(irq_lvl), int'(VECS[v][3:1]));
      chk($sformatf("R5 vec%0d irq_take", v), int'(irq_take), int'(VECS[v][0]));
    end

    // R1: reset state and defaults
    do_reset();
    mask = 3'd0;
    @(negedge clk);
    chk("R1 irq_lvl", int'(irq_lvl), 0);
    chk("R1 irq_take", int'(irq_take), 0);
    chk("R1 iack_done", int'(iack_done), 0);
    pulse(10'h3F0);  // internal sources default to level 0
    chk("R1 R3 internal disabled after reset", int'(irq_lvl), 0);
    ack(3);
    chk("R9 spurious done", int'(iack_done), 1);
    chk("R9 spurious flag", int'(iack_spur), 1);
    chk("R9 spurious vec", int'(iack_vec), 24);
    pulse(10'h002);
    ack(3);
    chk("R1 R8 default autovector vec", int'(iack_vec), 27);
    chk("R8 auto flag", int'(iack_auto), 1);

    // R2: alternate map and ignored level write on an external source
    do_reset();
    map_sel = 1'b1;
    pulse(10'h001);
    chk("R2 pin0 alt map", int'(irq_lvl), 2);
    wr(0, 7, 0, 0, 1'b1);
    @(negedge clk);
    chk("R2 pin0 level write ignored", int'(irq_lvl), 2);
    pulse(10'h004);
    chk("R2 pin2 alt map", int'(irq_lvl), 6);
    map_sel = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 pin2 default map", int'(irq_lvl), 5);

    // R6 R7 R10: tie-break and per-source clearing
    do_reset();
    setup_cfg();
    pulse(10'h180);
    ack(4);
    chk("R6 R7 lower index wins vec", int'(iack_vec), 8'h40);
    chk("R7 non-auto flag", int'(iack_auto), 0);
    @(negedge clk);
    chk("R10 other source still pending", int'(irq_lvl), 4);
    ack(4);
    chk("R10 second ack vec", int'(iack_vec), 8'h48);
    ack(4);
    chk("R10 R9 third ack spurious", int'(iack_spur), 1);
    wr(8, 4, 3, 8'h48, 1'b0);
    pulse(10'h180);
    ack(4);
    chk("R6 higher sub wins", int'(iack_vec), 8'h48);

    // R10: pending held without acknowledge, cleared by it
    do_reset();
    setup_cfg();
    pulse(10'h002);
    repeat (5) @(negedge clk);
    chk("R10 held pending", int'(irq_lvl), 3);
    ack(3);
    @(negedge clk);
    chk("R10 cleared after ack", int'(irq_lvl), 0);

    // R8 R5: top-level internal source autovector, taken at mask 7
    mask = 3'd7;
    pulse(10'h200);
    chk("R5 level 7 taken at mask 7", int'(irq_take), 1);
    ack(7);
    chk("R8 level 7 autovector", int'(iack_vec), 31);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule